// File: doc/BRIEF.md
# TDMA Epoch Slot Sequencer

This block plays back a repeating TDMA epoch one slot at a time. Each address of a small command store is one coarse time slot. A prescaler on the system clock marks slot boundaries. On each boundary the word for the current slot is decoded, its action is applied once, and the slot pointer moves on. The actions are: pulse a synthesizer lock request, mute or unmute the transmitter, start or stop the modulated transmit stream, or do nothing. A wait is written as a run of do-nothing words. For example, lock, twenty idle slots, unmute, one idle slot, then data on.

The host fills the store through a plain write port while the sequencer is stopped. It sets the index of the last slot of the epoch and raises the enable. After the last slot the pointer returns to slot zero on the very next boundary, so epochs run back to back with no gap. Lowering the enable stops playback, returns the pointer to slot zero and silences the transmitter. The RF circuitry outside the block is driven only by one strobe and two level outputs.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: After reset, `pll_lock_pulse`, `tx_unmuted` and `tx_data_on` are low and `cur_slot` is 0.
- R2: With `seq_en` raised, the word of slot k takes effect on the outputs exactly CLK_PER_SLOT*(k+1) clock cycles after the first rising edge that samples `seq_en` high. `cur_slot` changes only at those boundaries, and the outputs hold between them.
- R3: Opcode 1 (synthesizer lock) makes `pll_lock_pulse` high for exactly one clock cycle in its slot.
- R4: Opcode 3 sets `tx_unmuted` high and opcode 2 sets it low. The level holds until a later command changes it.
- R5: Opcode 4 sets `tx_data_on` high and opcode 5 sets it low. The level holds until a later command changes it.
- R6: The opcode is bits [3:0] of a word and all higher bits are ignored. Opcode 0 and the unassigned codes 6 to 15 change no output.
- R7: After the slot whose index equals the captured last-slot value, the next boundary executes slot 0. No idle slot is inserted between epochs.
- R8: While `seq_en` is low, `tx_unmuted` and `tx_data_on` are forced low one cycle later and `cur_slot` returns to 0. Raising `seq_en` again restarts playback at slot 0.
- R9: A write with `wr_en` high stores `wr_data` at `wr_addr` only while `seq_en` is low. A write while `seq_en` is high is ignored.
- R10: `epoch_last` is captured while `seq_en` is low. Changes to it while the sequencer runs have no effect until the next stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Run enable; low stops, rewinds and mutes |
| epoch_last | input | ADDR_W | Index of the final slot of the epoch |
| wr_en | input | 1 | Command store write strobe |
| wr_addr | input | ADDR_W | Slot index to write |
| wr_data | input | WORD_W | Command word; opcode in bits [3:0] |
| cur_slot | output | ADDR_W | Slot whose word runs at the next boundary |
| pll_lock_pulse | output | 1 | One-cycle synthesizer lock request |
| tx_unmuted | output | 1 | Transmitter unmute level |
| tx_data_on | output | 1 | Modulated transmit data enable level |

## Verification
The in-line properties assume that CLK_PER_SLOT is at least two, so that boundaries are never adjacent. They also assume that every input is synchronous to `clk`. The slot-pointer and level-hold properties depend on `seq_en` being the only thing that can rewind the pointer. The bench changes every input half a cycle after a rising edge and uses a short slot period. It writes only indices inside the store. It deliberately moves `epoch_last` and issues a write while running, so the capture and write-lock paths are exercised under the same timing the properties expect.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP         = 4'd0,
      OP_PLL_LOCK    = 4'd1,
      OP_TX_MUTE     = 4'd2,
      OP_TX_UNMUTE   = 4'd3,
      OP_TX_DATA_ON  = 4'd4,
      OP_TX_DATA_OFF = 4'd5
   } slot_op_e;
endpackage

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
   parameter int unsigned CLK_PER_SLOT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CNT_W = (CLK_PER_SLOT > 1) ? $clog2(CLK_PER_SLOT) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_PER_SLOT - 1);

   generate
      if (CLK_PER_SLOT < 2) begin : g_bad_div
         $error("slot_tick_gen: CLK_PER_SLOT must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == CNT_LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == CNT_LAST);

   // R2: boundaries are at least two cycles apart
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R2: no boundary in the cycle after a stopped cycle
   p_idle_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !tick);
endmodule

// File: rtl/slot_cmd_mem.sv
module slot_cmd_mem #(
   parameter int SLOT_DEPTH     = 64,
   parameter int WORD_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int ADDR_W        = $clog2(SLOT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   generate
      if ((1 << ADDR_W) != SLOT_DEPTH || SLOT_DEPTH < 2) begin : g_bad_depth
         $error("slot_cmd_mem: SLOT_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] mem_q [SLOT_DEPTH];
   logic              wr_take;

   assign wr_take = wr_en && !lock;

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SLOT_DEPTH; i++) begin
                  mem_q[i] <= '0;
               end
            end else if (wr_take) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_take) begin
               mem_q[wr_addr] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = mem_q[rd_addr];

   logic [WORD_W-1:0] wr_old;
   assign wr_old = mem_q[wr_addr];

   // R9: a write during playback leaves the word unchanged
   p_wr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock) |=> (mem_q[$past(wr_addr)] == $past(wr_old)));

   // R9: a write while stopped lands in the store
   p_wr_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !lock) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/slot_cmd_exec.sv
module slot_cmd_exec
   import tdma_seq_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [ADDR_W-1:0] epoch_last,
   output logic [ADDR_W-1:0] slot_q,
   output logic              pll_pulse,
   output logic              tx_unmuted,
   output logic              tx_data_on
);
   logic [ADDR_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q     <= '0;
         last_q     <= '0;
         pll_pulse  <= 1'b0;
         tx_unmuted <= 1'b0;
         tx_data_on <= 1'b0;
      end else begin
         pll_pulse <= 1'b0;
         if (!run) begin
            slot_q     <= '0;
            last_q     <= epoch_last;
            tx_unmuted <= 1'b0;
            tx_data_on <= 1'b0;
         end else if (tick) begin
            slot_q <= (slot_q == last_q) ? '0 : slot_q + 1'b1;
            case (opcode)
               OP_PLL_LOCK:    pll_pulse  <= 1'b1;
               OP_TX_MUTE:     tx_unmuted <= 1'b0;
               OP_TX_UNMUTE:   tx_unmuted <= 1'b1;
               OP_TX_DATA_ON:  tx_data_on <= 1'b1;
               OP_TX_DATA_OFF: tx_data_on <= 1'b0;
               default:        ;
            endcase
         end
      end
   end

   // R3: the lock strobe never lasts two cycles
   p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pll_pulse |=> !pll_pulse);

   // R7: the final slot of the epoch is followed by slot zero
   p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && slot_q == last_q) |=> (slot_q == '0));

   // R2: the pointer moves only on a boundary
   p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(slot_q));

   // R4 and R5: levels hold between boundaries
   p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> ($stable(tx_unmuted) && $stable(tx_data_on)));

   // R8: stopping silences the transmitter
   p_mute_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!tx_unmuted && !tx_data_on && slot_q == '0));

   // R10: the wrap point is frozen during playback
   p_epoch_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(last_q));
endmodule

// File: rtl/tdma_slot_sequencer.sv
module tdma_slot_sequencer
   import tdma_seq_pkg::*;
#(
   parameter int unsigned CLK_PER_SLOT = 1000,
   parameter int SLOT_DEPTH            = 64,
   parameter int WORD_W                = 8,
   parameter bit CLEAR_ON_RESET        = 1'b1,
   localparam int ADDR_W               = $clog2(SLOT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_en,
   input  logic [ADDR_W-1:0] epoch_last,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [ADDR_W-1:0] cur_slot,
   output logic              pll_lock_pulse,
   output logic              tx_unmuted,
   output logic              tx_data_on
);
   generate
      if (WORD_W < OPC_W) begin : g_bad_word
         $error("tdma_slot_sequencer: WORD_W must hold the opcode field");
      end
   endgenerate

   logic              slot_tick;
   logic [WORD_W-1:0] slot_word;
   logic [OPC_W-1:0]  slot_opc;

   slot_tick_gen #(
      .CLK_PER_SLOT(CLK_PER_SLOT)
   ) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (seq_en),
      .tick (slot_tick)
   );

   slot_cmd_mem #(
      .SLOT_DEPTH    (SLOT_DEPTH),
      .WORD_W        (WORD_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock   (seq_en),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(cur_slot),
      .rd_data(slot_word)
   );

   assign slot_opc = slot_word[OPC_W-1:0];

   generate
      if (WORD_W > OPC_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^slot_word[WORD_W-1:OPC_W];
      end
   endgenerate

   slot_cmd_exec #(
      .ADDR_W(ADDR_W)
   ) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (seq_en),
      .tick      (slot_tick),
      .opcode    (slot_opc),
      .epoch_last(epoch_last),
      .slot_q    (cur_slot),
      .pll_pulse (pll_lock_pulse),
      .tx_unmuted(tx_unmuted),
      .tx_data_on(tx_data_on)
   );
endmodule

// File: tb/tdma_slot_sequencer_tb.sv
module tdma_slot_sequencer_tb;
   localparam int DIV    = 6;
   localparam int DEPTH  = 16;
   localparam int AW     = 4;
   localparam int NVEC   = 16;

   // {word[7:0], expected pulse, expected unmuted, expected data}
   localparam logic [10:0] VEC [NVEC] = '{
      {8'h01, 3'b100}, {8'h00, 3'b000}, {8'h00, 3'b000}, {8'h00, 3'b000},
      {8'h03, 3'b010}, {8'h00, 3'b010}, {8'h04, 3'b011}, {8'h9F, 3'b011},
      {8'h01, 3'b111}, {8'h05, 3'b010}, {8'h30, 3'b010}, {8'h02, 3'b000},
      {8'hA3, 3'b010}, {8'h0E, 3'b010}, {8'h04, 3'b011}, {8'h02, 3'b001}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seq_en = 1'b0;
   logic [AW-1:0] epoch_last = 4'd15;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] cur_slot;
   logic          pll_lock_pulse, tx_unmuted, tx_data_on;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   tdma_slot_sequencer #(
      .CLK_PER_SLOT(DIV),
      .SLOT_DEPTH  (DEPTH),
      .WORD_W      (8)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .seq_en        (seq_en),
      .epoch_last    (epoch_last),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .cur_slot      (cur_slot),
      .pll_lock_pulse(pll_lock_pulse),
      .tx_unmuted    (tx_unmuted),
      .tx_data_on    (tx_data_on)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input int p, input int u, input int d, input int s);
      chk(req, "pll_lock_pulse", int'(pll_lock_pulse), p);
      chk(req, "tx_unmuted", int'(tx_unmuted), u);
      chk(req, "tx_data_on", int'(tx_data_on), d);
      chk(req, "cur_slot", int'(cur_slot), s);
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic next_slot();
      repeat (DIV) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic string tag_for(input logic [7:0] w, input int k);
      if (k == 2) return "R9";
      case (w[3:0])
         4'd1:       return "R3";
         4'd2, 4'd3: return "R4";
         4'd4, 4'd5: return "R5";
         default:    return "R6";
      endcase
   endfunction

   initial begin
      int pu, pd;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk_out("R1", 0, 0, 0, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) host_write(AW'(i), VEC[i][10:3]);
      epoch_last = 4'd15;
      @(negedge clk);
      seq_en = 1'b1;

      pu = 0; pd = 0;
      for (int k = 0; k < NVEC; k++) begin
         repeat (DIV - 1) @(posedge clk);
         @(negedge clk);
         // R2: one cycle before the boundary nothing has moved yet
         chk_out("R2", 0, pu, pd, k);
         if (k == 0) begin
            // R9: write during playback must be dropped
            wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h01;
         end
         @(posedge clk);
         @(negedge clk);
         wr_en = 1'b0;
         chk_out(tag_for(VEC[k][10:3], k), int'(VEC[k][2]), int'(VEC[k][1]),
                 int'(VEC[k][0]), (k + 1) % DEPTH);
         pu = int'(VEC[k][1]);
         pd = int'(VEC[k][0]);
      end

      // R7: slot 0 follows slot 15 one slot period later
      next_slot();
      chk_out("R7", 1, 0, 1, 1);

      // R8: stop silences and rewinds
      seq_en = 1'b0;
      @(negedge clk);
      chk_out("R8", 0, 0, 0, 0);

      // R10: capture a short epoch, then move epoch_last while running
      epoch_last = 4'd2;
      host_write(4'd1, 8'h03);
      @(negedge clk);
      seq_en = 1'b1;
      epoch_last = 4'd15;
      next_slot();
      chk_out("R8", 1, 0, 0, 1);
      next_slot();
      chk_out("R9", 0, 1, 0, 2);
      next_slot();
      chk_out("R10", 0, 1, 0, 0);
      next_slot();
      chk_out("R10", 1, 1, 0, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completion)");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule